// File: doc/BRIEF.md
# High-Bandwidth Isochronous IN Bank Scheduler

This block schedules the transmit banks of one high-bandwidth isochronous IN endpoint in a USB device controller. In each micro-frame the host is expected to issue between one and three IN tokens. The block tracks which banks the CPU has loaded and points the packet engine at the bank for the next transaction. When a token finds no loaded bank, it requests an automatic zero-length packet. At each micro-frame boundary it checks whether the CPU supplied enough data.

If at least one packet went out and some expected tokens never arrived, the banks still holding data for that micro-frame are discarded. This keeps later data aligned to its own micro-frame. The underflow condition and the supply shortfall are reported as sticky interrupt flags, and each flag is cleared by a one-cycle acknowledge.

Top module: `hbi_sched`

## Requirements
- R1: The number of expected transactions per micro-frame is `cfg_ntrans`. The legal values are 1 to 3. A value of 0 acts as 1. The expected banks are indices 0 to n-1.
- R2: `bank_sel` names the bank for the next transaction. It advances by one on `pkt_sent`, or on an IN token that finds no loaded bank, as long as it is below n. It then holds at n.
- R3: An IN token that finds the selected bank empty, or `bank_sel` equal to n, causes the following. In the next cycle, `zlp_req` pulses for one cycle and the underflow flag `irq_underflow` sets.
- R4: An expected IN token that never arrives does not set the underflow flag.
- R5: On `mf_end`, `irq_hberr` sets in the next cycle if any expected bank was neither loaded at the start of the micro-frame nor loaded during it. A load in the same cycle as `mf_end` counts as loaded.
- R6: On `mf_end`, a flush happens when at least one packet was sent in the micro-frame and fewer than n tokens arrived. The flush empties every loaded bank from `bank_sel` up to n-1. `flush_strobe` bit i pulses in the next cycle for each bank emptied. Example: with n=3 and one token, banks 1 and 2 are flushed, giving 3'b110.
- R7: After `mf_end`, `bank_sel` is 0, and the token count and sent record restart for the new micro-frame.
- R8: Both interrupt flags stay set until their acknowledge input is high. If a set and an acknowledge happen in the same cycle, the flag stays set.
- R9: A bank loaded through `fill_set` becomes full. A bank consumed by `pkt_sent`, or flushed, becomes empty. A load in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ntrans | input | 2 | Transactions per micro-frame (1..3) |
| mf_end | input | 1 | Micro-frame boundary strobe |
| fill_set | input | 3 | CPU has loaded bank i (one-cycle per bit) |
| in_token | input | 1 | IN token received strobe |
| pkt_sent | input | 1 | Packet from the selected bank was sent |
| ack_underflow | input | 1 | Clear the underflow flag |
| ack_hberr | input | 1 | Clear the shortfall flag |
| bank_sel | output | 2 | Bank for the next transaction |
| zlp_req | output | 1 | Send a zero-length packet |
| irq_underflow | output | 1 | Sticky underflow flag |
| irq_hberr | output | 1 | Sticky supply-shortfall flag |
| flush_strobe | output | 3 | One-cycle pulse per flushed bank |

## Verification
The hardest case to reach is a flush. It needs a micro-frame in which a packet was really sent, the host then stopped short of n tokens, and banks beyond the pointer still hold data. A flush of only part of the banks also needs some of those banks left unloaded. The directed part builds the three-transaction case with a single token. The random part loads banks at random, and it also issues tokens at random, each followed by a packet-sent strobe when a bank was loaded. Its micro-frame ends are frequent, so short micro-frames that still carry a sent packet occur often.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int unsigned HBI_BANKS = 3;

  // clamp a configured transaction count into 1..nb
  function automatic logic [1:0] hbi_eff_count(input logic [1:0] cfg, input int unsigned nb);
    if (cfg == 2'd0) return 2'd1;
    if (int'(cfg) > int'(nb)) return 2'(nb);
    return cfg;
  endfunction
endpackage

// File: rtl/hbi_sticky.sv
module hbi_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/hbi_bank_state.sv
module hbi_bank_state #(
  parameter int unsigned NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mf_end_i,
  input  logic [NB-1:0] fill_i,
  input  logic [NB-1:0] consume_i,
  input  logic [NB-1:0] flush_i,
  input  logic [NB-1:0] exp_i,
  output logic [NB-1:0] full_o,
  output logic          short_o
);
  logic [NB-1:0] full_d, sup_q, sup_d;

  always_comb begin
    full_d  = (full_o & ~consume_i & ~flush_i) | fill_i;
    sup_d   = mf_end_i ? full_d : (sup_q | fill_i);
    short_o = mf_end_i & |(exp_i & ~(sup_q | fill_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= '0;
      sup_q  <= '0;
    end else begin
      full_o <= full_d;
      sup_q  <= sup_d;
    end
  end
endmodule

// File: rtl/hbi_sched.sv
module hbi_sched
  import hbi_pkg::*;
#(
  parameter int unsigned NB    = HBI_BANKS,
  localparam int unsigned PW   = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_ntrans,
  input  logic          mf_end,
  input  logic [NB-1:0] fill_set,
  input  logic          in_token,
  input  logic          pkt_sent,
  input  logic          ack_underflow,
  input  logic          ack_hberr,
  output logic [PW-1:0] bank_sel,
  output logic          zlp_req,
  output logic          irq_underflow,
  output logic          irq_hberr,
  output logic [NB-1:0] flush_strobe
);
  logic [PW-1:0] nt, ptr_d, tok_q, tok_d;
  logic          sent_q, sent_d, cur_full, in_range, empty_tok, short_w;
  logic [NB-1:0] exp_mask, full_w, consume, flush_w;

  always_comb begin
    if (cfg_ntrans == '0)            nt = PW'(1);
    else if (cfg_ntrans > PW'(NB))   nt = PW'(NB);
    else                             nt = cfg_ntrans;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_bank
      assign exp_mask[gi] = PW'(gi) < nt;
      assign consume[gi]  = pkt_sent & ~mf_end & in_range & (bank_sel == PW'(gi));
      assign flush_w[gi]  = mf_end & sent_q & (tok_q < nt) & exp_mask[gi]
                            & (PW'(gi) >= bank_sel) & full_w[gi];
    end
  endgenerate

  always_comb begin
    in_range = bank_sel < nt;
    cur_full = 1'b0;
    for (int i = 0; i < NB; i++)
      if (bank_sel == PW'(i)) cur_full = full_w[i];
    cur_full  = cur_full & in_range;
    empty_tok = in_token & ~mf_end & ~cur_full;
  end

  always_comb begin
    ptr_d  = bank_sel;
    tok_d  = tok_q;
    sent_d = sent_q;
    if (mf_end) begin
      ptr_d  = '0;
      tok_d  = '0;
      sent_d = 1'b0;
    end else begin
      if ((pkt_sent | empty_tok) & in_range) ptr_d = bank_sel + PW'(1);
      if (in_token && tok_q < PW'(NB))       tok_d = tok_q + PW'(1);
      if (pkt_sent)                          sent_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_sel     <= '0;
      tok_q        <= '0;
      sent_q       <= 1'b0;
      zlp_req      <= 1'b0;
      flush_strobe <= '0;
    end else begin
      bank_sel     <= ptr_d;
      tok_q        <= tok_d;
      sent_q       <= sent_d;
      zlp_req      <= empty_tok;
      flush_strobe <= flush_w;
    end
  end

  hbi_bank_state #(.NB(NB)) u_banks (
    .clk(clk), .rst_n(rst_n), .mf_end_i(mf_end), .fill_i(fill_set),
    .consume_i(consume), .flush_i(flush_w), .exp_i(exp_mask),
    .full_o(full_w), .short_o(short_w)
  );

  hbi_sticky u_uf (.clk(clk), .rst_n(rst_n), .set_i(empty_tok),
                   .clr_i(ack_underflow), .q_o(irq_underflow));
  hbi_sticky u_he (.clk(clk), .rst_n(rst_n), .set_i(short_w),
                   .clr_i(ack_hberr), .q_o(irq_hberr));
endmodule

// File: rtl/hbi_sched_chk.sv
module hbi_sched_chk #(
  parameter int unsigned NB = 3,
  localparam int unsigned PW = $clog2(NB + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mf_end,
  input logic          in_token,
  input logic          ack_underflow,
  input logic          ack_hberr,
  input logic [PW-1:0] bank_sel,
  input logic          zlp_req,
  input logic          irq_underflow,
  input logic          irq_hberr,
  input logic [NB-1:0] flush_strobe
);
  p_zlp_needs_token_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_req |-> $past(in_token) && !$past(mf_end));
  p_zlp_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_req |-> irq_underflow);
  p_flush_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush_strobe) |-> $past(mf_end));
  p_hberr_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hberr) |-> $past(mf_end));
  p_ptr_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mf_end |=> bank_sel == '0);
  p_uf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_underflow && !ack_underflow) |=> irq_underflow);
  p_he_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hberr && !ack_hberr) |=> irq_hberr);
endmodule

bind hbi_sched hbi_sched_chk #(.NB(NB)) u_chk (.*);

// File: tb/hbi_sched_bench.sv
module hbi_sched_bench;
  localparam int NB = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_ntrans = 2'd3;
  logic mf_end = 0, in_token = 0, pkt_sent = 0, ack_underflow = 0, ack_hberr = 0;
  logic [NB-1:0] fill_set = '0;
  logic [1:0] bank_sel;
  logic zlp_req, irq_underflow, irq_hberr;
  logic [NB-1:0] flush_strobe;

  int n_chk = 0, n_bad = 0;

  // reference state
  logic [NB-1:0] m_full, m_sup;
  logic [1:0] m_ptr, m_tok;
  logic m_sent, m_uf, m_he, m_zlp;
  logic [NB-1:0] m_flush;

  always #2ns clk = ~clk;

  hbi_sched u_hbi_sched (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] eff(input logic [1:0] c);
    return (c == 0) ? 2'd1 : c;
  endfunction

  task automatic step(input logic [NB-1:0] f, input logic tk, input logic ps,
                      input logic me, input logic au, input logic ah);
    logic [1:0] nt;
    logic cur, emp, sh, inr;
    logic [NB-1:0] fl, cons;
    @(negedge clk);
    fill_set = f; in_token = tk; pkt_sent = ps; mf_end = me;
    ack_underflow = au; ack_hberr = ah;
    nt  = eff(cfg_ntrans);
    inr = m_ptr < nt;
    cur = inr && m_full[m_ptr];
    emp = tk && !me && !cur;
    sh  = me && |(((3'b1 << nt) - 3'b1) & ~(m_sup | f));
    fl  = '0;
    if (me && m_sent && m_tok < nt)
      for (int i = 0; i < NB; i++)
        if (i >= m_ptr && i < nt && m_full[i]) fl[i] = 1'b1;
    cons = (ps && !me && inr) ? (3'b1 << m_ptr) : 3'b0;
    m_full = (m_full & ~cons & ~fl) | f;
    if (me) begin
      m_sup = m_full; m_ptr = 0; m_tok = 0; m_sent = 0;
    end else begin
      m_sup = m_sup | f;
      if ((ps || emp) && inr) m_ptr = m_ptr + 1;
      if (tk && m_tok < 3) m_tok = m_tok + 1;
      if (ps) m_sent = 1;
    end
    m_zlp = emp;
    m_flush = fl;
    m_uf = emp | (m_uf & !au);
    m_he = sh | (m_he & !ah);
    @(posedge clk); #1ns;
    check("R2 bank_sel", bank_sel, m_ptr);
    check("R3 zlp_req", zlp_req, m_zlp);
    check("R8 irq_underflow", irq_underflow, m_uf);
    check("R5 irq_hberr", irq_hberr, m_he);
    check("R6 flush_strobe", flush_strobe, m_flush);
    fill_set = '0; in_token = 0; pkt_sent = 0; mf_end = 0;
    ack_underflow = 0; ack_hberr = 0;
  endtask

  // token followed by packet-sent when a bank was ready
  task automatic xfer();
    logic had;
    had = (m_ptr < eff(cfg_ntrans)) && m_full[m_ptr];
    step('0, 1, 0, 0, 0, 0);
    if (had) step('0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #(4ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_full = '0; m_sup = '0; m_ptr = 0; m_tok = 0; m_sent = 0;
    m_uf = 0; m_he = 0; m_zlp = 0; m_flush = '0;
    #10ns; @(negedge clk); rst_n = 1;
    @(posedge clk); #1ns;
    check("R7 reset bank_sel", bank_sel, 0);
    check("R8 reset flags", {irq_underflow, irq_hberr, zlp_req}, 0);
    check("R6 reset flush", flush_strobe, 0);

    // R6 example: three expected, one token, banks 1 and 2 discarded
    cfg_ntrans = 2'd3;
    step(3'b111, 0, 0, 0, 0, 0);
    step('0, 0, 0, 1, 0, 1);
    xfer();
    check("R2 advance after send", bank_sel, 1);
    step('0, 0, 0, 1, 0, 0);
    check("R6 example flush", flush_strobe, 3'b110);
    check("R5 no shortfall when loaded", irq_hberr, 0);
    check("R7 pointer restart", bank_sel, 0);
    check("R9 flushed banks empty", {1'b0, zlp_req}, 0);
    // R9/R3: bank 1 is now empty, tokens after bank 0 underflow
    step(3'b001, 0, 0, 0, 0, 0);
    xfer();
    xfer();
    check("R9 flushed bank empty -> zlp", zlp_req, 1);
    check("R3 underflow set", irq_underflow, 1);
    // R8: ack with simultaneous set keeps flag
    step('0, 1, 0, 0, 1, 0);
    check("R8 set wins over ack", irq_underflow, 1);
    step('0, 0, 0, 0, 1, 0);
    check("R8 ack clears", irq_underflow, 0);
    // R5: banks 1,2 never loaded this micro-frame
    step('0, 0, 0, 1, 0, 0);
    check("R5 shortfall flagged", irq_hberr, 1);
    step('0, 0, 0, 0, 0, 1);
    // R4: loaded banks, no tokens at all -> no underflow, no flush
    step(3'b111, 0, 0, 1, 0, 1);
    step('0, 0, 0, 1, 0, 0);
    check("R4 missing tokens no underflow", irq_underflow, 0);
    check("R6 no flush without send", flush_strobe, 0);
    // R1: cfg 0 acts as one transaction, all tokens arrive -> no flush
    cfg_ntrans = 2'd0;
    xfer();
    check("R1 single transaction pointer", bank_sel, 1);
    step('0, 0, 0, 1, 0, 0);
    check("R1 one expected, no flush", flush_strobe, 0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: step(3'b1 << $urandom_range(0, NB - 1), 0, 0, 0, 0, 0);
        3, 4, 5: xfer();
        6:       step('0, 0, 0, 0, 0, 0);
        7: begin
             step(3'($urandom), 0, 0, 1, 0, 0);
             cfg_ntrans = 2'($urandom_range(0, 3));
           end
        default: step('0, 0, 0, 0, 1'($urandom), 1'($urandom));
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule